// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Bank

This block gathers eight external input lines into one interrupt source. Each line is first brought into the sampling domain through a two-stage synchronizer. A sample strobe decides when the synchronizer advances. Tie the strobe high and the bank behaves like a synchronized input port running at the bus clock. Pulse it from a slow timebase, such as a 32 kHz tick, and the bank sees the inputs only at that rate. Each channel has its own trigger type: rising edge, falling edge, either edge, high level or low level.

Software reaches the bank through a simple word-addressed register port. Address bits [4:2] select the register, and channel i always maps to data bit i. The port holds per-channel enable, trigger-type and polarity settings, and returns raw status, enabled status and the synchronized input levels. A write-one-to-acknowledge register clears pending status. The single interrupt output is the OR of the enabled status bits, so several banks can share one line by ORing these outputs together.

Top module: `eicb_bank`

## Requirements
- R1: After reset every register reads zero except the input-level register, which reads the synchronized inputs, and `irq_o` is low.
- R2: The enable (0x00), level-select (0x10), any-edge (0x14) and polarity (0x18) registers read back the value last written to bits [7:0], one bit per channel. The acknowledge register (0x0C) always reads zero.
- R3: With level-select 0 and any-edge 0, a channel sets its raw-status bit (0x04) on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The bit is set no later than the third clock edge after the pin changes. It then stays set until acknowledged.
- R4: With any-edge 1, a channel sets its raw-status bit on either edge, whatever its level-select and polarity bits hold. The bit stays set until acknowledged.
- R5: With level-select 1 and any-edge 0, the raw-status bit follows the synchronized input. It is set while the input is high (polarity 1) or low (polarity 0), and it drops once the input leaves that level.
- R6: Writing 1 to a bit of 0x0C clears that raw-status bit, and 0 bits have no effect. A level channel whose level persists sets its bit again on the following cycle. An edge detected in the same cycle as the acknowledge keeps the bit set.
- R7: Enabled status (0x08) equals raw status AND enable, and `irq_o` is high exactly when enabled status is non-zero.
- R8: The input-level register (0x1C) shows each pin after two sampling stages. A pin change made before clock edge k is visible after edge k+1.
- R9: The synchronizer and the edge history advance only on clock edges where `smp_en` is high. A pin pulse that begins and ends while `smp_en` is low leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe; high advances the input synchronizers |
| pin_i | input | NCH | Raw external input lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address (bits [4:2] decoded) |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data for `addr` (combinational) |
| irq_o | output | 1 | OR of the enabled status bits |

## Verification
Four properties are checked on every cycle. Raw status is zero right after reset. A sticky status bit never drops without an acknowledge while its configuration is steady. The interrupt stays silent whenever every enable is off. The sampled inputs hold still on cycles without a strobe. An enable write is also seen in the following cycle. The bench scenarios are the only evidence for the actual trigger selection: the five trigger types, any-edge overriding the other two bits, one-cycle re-assertion of a held level, exact synchronizer latency, and loss of a pulse that falls between strobes.

// File: rtl/eicb_pkg.sv
package eicb_pkg;

    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_EN  = 3'd0,
        SEL_RAW = 3'd1,
        SEL_MSK = 3'd2,
        SEL_ACK = 3'd3,
        SEL_LVL = 3'd4,
        SEL_ANY = 3'd5,
        SEL_POL = 3'd6,
        SEL_DIN = 3'd7
    } sel_e;

    typedef struct packed {
        logic lvl;   // 1: level trigger, 0: edge trigger
        logic any;   // 1: either edge, overrides lvl and pol
        logic pol;   // 1: rising / high, 0: falling / low
    } trig_cfg_t;

    // Edge checks use fresh so that a held cur/prv pair does not re-fire
    function automatic logic trig_fire(trig_cfg_t c, logic cur, logic prv, logic fresh);
        if (c.any)
            return fresh & (cur ^ prv);
        if (c.lvl)
            return c.pol ? cur : ~cur;
        return fresh & (c.pol ? (cur & ~prv) : (~cur & prv));
    endfunction

    function automatic logic trig_sticky(trig_cfg_t c);
        return c.any | ~c.lvl;
    endfunction

endpackage

// File: rtl/eicb_sync.sv
module eicb_sync #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           smp_en,
    input  logic [NCH-1:0] pin_i,
    output logic [NCH-1:0] cur_o,
    output logic [NCH-1:0] prv_o,
    output logic           fresh_o
);
    logic [NCH-1:0] meta_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                cur_o[i]  <= 1'b0;
                prv_o[i]  <= 1'b0;
            end else if (smp_en) begin
                meta_q[i] <= pin_i[i];
                cur_o[i]  <= meta_q[i];
                prv_o[i]  <= cur_o[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fresh_o <= 1'b0;
        else     fresh_o <= smp_en;
    end
endmodule

// File: rtl/eicb_detect.sv
module eicb_detect
    import eicb_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  trig_cfg_t [NCH-1:0]       cfg_i,
    input  logic      [NCH-1:0]       cur_i,
    input  logic      [NCH-1:0]       prv_i,
    input  logic                      fresh_i,
    input  logic      [NCH-1:0]       ack_i,
    output logic      [NCH-1:0]       raw_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        always_comb hit = trig_fire(cfg_i[i], cur_i[i], prv_i[i], fresh_i);

        always_ff @(posedge clk) begin
            if (rst)
                raw_o[i] <= 1'b0;
            else if (trig_sticky(cfg_i[i]))
                raw_o[i] <= hit | (raw_o[i] & ~ack_i[i]);
            else
                raw_o[i] <= hit & ~ack_i[i];
        end
    end
endmodule

// File: rtl/eicb_regs.sv
module eicb_regs
    import eicb_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DW-1:0]         wdata,
    input  logic [NCH-1:0]        raw_i,
    input  logic [NCH-1:0]        cur_i,
    output trig_cfg_t [NCH-1:0]   cfg_o,
    output logic [NCH-1:0]        en_o,
    output logic [NCH-1:0]        ack_o,
    output logic [DW-1:0]         rdata,
    output logic                  irq_o
);
    localparam int PAD = DW - NCH;

    sel_e           sel;
    logic [NCH-1:0] lvl_q, any_q, pol_q, en_q, rd_bits, msk;

    always_comb sel = sel_e'(addr[4:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lvl_q <= '0;
            any_q <= '0;
            pol_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_EN:  en_q  <= wdata[NCH-1:0];
                SEL_LVL: lvl_q <= wdata[NCH-1:0];
                SEL_ANY: any_q <= wdata[NCH-1:0];
                SEL_POL: pol_q <= wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cfg
        always_comb cfg_o[i] = '{lvl: lvl_q[i], any: any_q[i], pol: pol_q[i]};
    end

    always_comb begin
        msk   = raw_i & en_q;
        en_o  = en_q;
        ack_o = (wr_en && sel == SEL_ACK) ? wdata[NCH-1:0] : '0;
        irq_o = |msk;
        case (sel)
            SEL_EN:  rd_bits = en_q;
            SEL_RAW: rd_bits = raw_i;
            SEL_MSK: rd_bits = msk;
            SEL_LVL: rd_bits = lvl_q;
            SEL_ANY: rd_bits = any_q;
            SEL_POL: rd_bits = pol_q;
            SEL_DIN: rd_bits = cur_i;
            default: rd_bits = '0;
        endcase
        rdata = {{PAD{1'b0}}, rd_bits};
    end
endmodule

// File: rtl/eicb_bank.sv
module eicb_bank
    import eicb_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_en,
    input  logic [NCH-1:0]      pin_i,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic                irq_o
);
    trig_cfg_t [NCH-1:0] cfg;
    logic [NCH-1:0]      cur, prv, raw, ack, en;
    logic                fresh;

    eicb_sync #(.NCH(NCH)) u_sync (
        .clk(clk), .rst(rst), .smp_en(smp_en), .pin_i(pin_i),
        .cur_o(cur), .prv_o(prv), .fresh_o(fresh)
    );

    eicb_detect #(.NCH(NCH)) u_det (
        .clk(clk), .rst(rst), .cfg_i(cfg), .cur_i(cur), .prv_i(prv),
        .fresh_i(fresh), .ack_i(ack), .raw_o(raw)
    );

    eicb_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .raw_i(raw), .cur_i(cur), .cfg_o(cfg), .en_o(en), .ack_o(ack),
        .rdata(rdata), .irq_o(irq_o)
    );
endmodule

// File: rtl/eicb_bank_chk.sv
module eicb_bank_chk
    import eicb_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_en,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DW-1:0]       wdata,
    input trig_cfg_t [NCH-1:0] cfg,
    input logic [NCH-1:0]      en,
    input logic [NCH-1:0]      raw,
    input logic [NCH-1:0]      ack,
    input logic [NCH-1:0]      cur,
    input logic                irq_o
);
    logic [NCH-1:0] stk;
    for (genvar i = 0; i < NCH; i++) begin : g_stk
        always_comb stk[i] = trig_sticky(cfg[i]);
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (raw == '0 && !irq_o));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg) |-> (($past(raw & stk & ~ack) & ~raw) == '0));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq_o);

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[4:2] == 3'd0) |=> (en == $past(wdata[NCH-1:0])));

    // R9
    hold_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(cur));
endmodule

bind eicb_bank eicb_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .smp_en(smp_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cfg(cfg), .en(en), .raw(raw), .ack(ack), .cur(cur),
    .irq_o(irq_o)
);

// File: tb/eicb_bank_test.sv
module eicb_bank_test;
    localparam int NCH = 8;
    localparam int DW  = 32;
    localparam logic [4:0] A_EN = 5'h00, A_RAW = 5'h04, A_MSK = 5'h08, A_ACK = 5'h0C,
                           A_LVL = 5'h10, A_ANY = 5'h14, A_POL = 5'h18, A_DIN = 5'h1C;
    // fields: [5] level-select [4] any-edge [3] polarity [2] first pin [1] second pin [0] expected raw
    localparam logic [5:0] VEC [0:10] = '{
        6'b001011, 6'b001100, 6'b000101, 6'b000010, 6'b010011, 6'b011101,
        6'b111110, 6'b101011, 6'b101100, 6'b100101, 6'b100010 };

    logic clk = 1'b0, rst = 1'b1, smp_en = 1'b1, wr_en = 1'b0, irq_o;
    logic [NCH-1:0] pin_i = '0;
    logic [4:0]     addr = '0;
    logic [DW-1:0]  wdata = '0, rdata;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    eicb_bank #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .pin_i(pin_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [7:0] l, input logic [7:0] b, input logic [7:0] p, input logic [7:0] e);
        wr(A_LVL, {24'h0, l}); wr(A_ANY, {24'h0, b}); wr(A_POL, {24'h0, p}); wr(A_EN, {24'h0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3); rst = 1'b0; idle(1);

        // R1 reset state
        rd(A_EN, v);  chk("R1 en", v, 0);
        rd(A_RAW, v); chk("R1 raw", v, 0);
        rd(A_MSK, v); chk("R1 msk", v, 0);
        rd(A_LVL, v); chk("R1 lvl", v, 0);
        rd(A_POL, v); chk("R1 pol", v, 0);
        chk("R1 irq", {31'h0, irq_o}, 0);

        // R2 readback
        cfg(8'h3C, 8'h0F, 8'hF0, 8'hA5);
        rd(A_EN, v);  chk("R2 en", v, 32'hA5);
        rd(A_LVL, v); chk("R2 lvl", v, 32'h3C);
        rd(A_ANY, v); chk("R2 any", v, 32'h0F);
        rd(A_POL, v); chk("R2 pol", v, 32'hF0);
        rd(A_ACK, v); chk("R2 ack reads zero", v, 0);

        // vector table: R3 R4 R5 trigger types
        for (int i = 0; i < 11; i++) begin
            int ch = i % NCH;
            logic [5:0] t = VEC[i];
            cfg(8'(t[5]) << ch, 8'(t[4]) << ch, 8'(t[3]) << ch, 8'h00);
            pin_i = 8'(t[2]) << ch; idle(5);
            wr(A_ACK, 32'hFF);
            pin_i = 8'(t[1]) << ch; idle(5);
            rd(A_RAW, v);
            chk($sformatf("R3 R4 R5 vector %0d", i), {31'h0, v[ch]}, {31'h0, t[0]});
        end

        // R3 sticky after return to idle level
        pin_i = '0; cfg(8'h00, 8'h00, 8'h04, 8'h00); idle(5); wr(A_ACK, 32'hFF);
        pin_i = 8'h04; idle(4); pin_i = 8'h00; idle(10);
        rd(A_RAW, v); chk("R3 sticky", {31'h0, v[2]}, 1);
        // R6 zero bits have no effect
        wr(A_ACK, 32'hFB); rd(A_RAW, v); chk("R6 zero ack ignored", {31'h0, v[2]}, 1);
        // R7 masking and irq
        chk("R7 irq off when disabled", {31'h0, irq_o}, 0);
        rd(A_MSK, v); chk("R7 msk zero", v, 0);
        wr(A_EN, 32'h04);
        chk("R7 irq on", {31'h0, irq_o}, 1);
        rd(A_MSK, v); chk("R7 msk", v, 32'h04);
        wr(A_ACK, 32'h04);
        rd(A_RAW, v); chk("R6 edge ack", {31'h0, v[2]}, 0);
        chk("R7 irq drops", {31'h0, irq_o}, 0);

        // R6 level re-assertion after ack
        cfg(8'h20, 8'h00, 8'h20, 8'h00); pin_i = 8'h20; idle(5);
        wr(A_ACK, 32'h20);
        rd(A_RAW, v); chk("R6 level cleared one cycle", {31'h0, v[5]}, 0);
        idle(1);
        rd(A_RAW, v); chk("R6 level re-asserts", {31'h0, v[5]}, 1);
        pin_i = 8'h00; idle(4);
        rd(A_RAW, v); chk("R5 level drops", {31'h0, v[5]}, 0);

        // R8 synchronizer latency
        idle(2);
        @(negedge clk); pin_i = 8'h5A;
        @(negedge clk); rd(A_DIN, v); chk("R8 not yet", v, 0);
        @(negedge clk); rd(A_DIN, v); chk("R8 visible", v, 32'h5A);

        // R9 strobe low freezes sampling
        cfg(8'h00, 8'h00, 8'h01, 8'h00); idle(2); wr(A_ACK, 32'hFF);
        @(negedge clk); smp_en = 1'b0; pin_i = 8'h00; idle(5);
        rd(A_DIN, v); chk("R9 din frozen", v, 32'h5A);
        pin_i = 8'h01; idle(2); pin_i = 8'h00; idle(2);
        smp_en = 1'b1; idle(5);
        rd(A_RAW, v); chk("R9 pulse between strobes lost", {31'h0, v[0]}, 0);
        rd(A_DIN, v); chk("R9 din resumes", v, 0);
        wr(A_ACK, 32'hFF);
        pin_i = 8'h01; idle(2); pin_i = 8'h00; idle(5);
        rd(A_RAW, v); chk("R9 sampled pulse caught", {31'h0, v[0]}, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule